// File: doc/BRIEF.md
# Sequential Single-Precision Multiplier

This unit multiplies two 32-bit binary floating-point numbers over a fixed number of clock cycles. A caller presents both operands with a one-cycle load pulse while the unit is idle. The operands are registered on that edge and the unit raises `busy`. Exactly ten cycles later it publishes the rounded product together with a three-bit classification of the result and drops `busy`. The product and flags stay unchanged until the next operation completes. A new load may be issued in the same cycle that `busy` is seen low.

The datapath covers all operand classes: zeros, subnormals, normals, infinities and NaNs. Subnormal operands are first normalised with a leading-zero count. The full 48-bit significand product is then aligned, and shifted right into the subnormal range when the exponent underflows. Rounding is to nearest with ties to even. Exponent overflow after rounding saturates to infinity.

Top module: `fp32_seqmul`

## Requirements
- R1: Operands and product use sign in bit 31, biased exponent (bias 127) in bits 30:23 and fraction in bits 22:0. The product sign is the XOR of the operand signs for every operand class, including zero, infinity and NaN.
- R2: When `load` is high while `busy` is low, the operands are captured at that rising edge and `busy` is high from that edge onward. A `load` while `busy` is high is ignored and does not alter the operation in progress.
- R3: `busy` stays high for exactly 10 clock cycles after the capture edge, then falls. In the same edge, `prod` and `flags` take the new result. They hold that result until the next operation completes. A load in the first idle cycle is accepted.
- R4: Finite non-zero products in the normal range are rounded to nearest, ties to even.
- R5: `flags` is 3'b100 for a NaN result, 3'b010 for an infinite result, 3'b001 for a subnormal result and 3'b000 otherwise. At most one bit is ever set.
- R6: A NaN operand, or zero times infinity, gives exponent 8'hFF with fraction 23'h400000 (0x7FC00000 with the XOR sign) and `flags` = 3'b100.
- R7: An infinite operand times a non-zero, non-NaN operand, or a rounded exponent of 255 or more, gives a signed infinity (exponent 8'hFF, fraction 0) with `flags` = 3'b010.
- R8: Products below the smallest normal are delivered as subnormals (exponent 0), rounded to nearest even with `flags` = 3'b001. A product that rounds to zero is delivered as a signed zero with `flags` = 3'b000.
- R9: Subnormal operands are accepted and handled by value; for example, 2^-149 times 2^23 gives exactly 2^-126 (0x00800000).
- R10: A zero operand times any finite operand gives a zero with the XOR sign and `flags` = 3'b000.
- R11: While reset is held low, and after it is released, `busy`, `prod` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start strobe, honoured only while idle |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| prod | output | 32 | Rounded product, valid while `busy` is low |
| flags | output | 3 | Result class: bit 2 NaN, bit 1 infinity, bit 0 subnormal |
| busy | output | 1 | High while an operation is in progress |

## Verification
The product path is exercised with several operand pairs:
- Exact small-integer products check alignment and sign.
- Pairs whose exact product sits exactly halfway between two representable values, one with an odd and one with an even lower neighbour, separate round-half-even from round-half-up and from truncation.
- A product just under the normal range, and subnormal operands that land on the smallest normal, at the halfway point to zero, and just above it, check the right-shift, sticky collection and pre-normalisation.
- Special operand pairs each map to a single flag code, so a wrong priority between NaN, infinity and zero shows up directly.
- Directed sequences check the ten-cycle busy window, a load ignored mid-operation, result hold while idle, and a reload in the first idle cycle.

// File: rtl/fp32_seqmul.sv
module fp32_seqmul #(
  parameter int LAT = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  output logic [31:0] prod,
  output logic [2:0]  flags,
  output logic        busy
);
  localparam int CW = $clog2(LAT + 1);

  logic [31:0]   a_q, b_q;
  logic [CW-1:0] cnt;

  function automatic logic [4:0] lzc24(input logic [23:0] v);
    lzc24 = 5'd24;
    for (int i = 0; i < 24; i++)
      if (v[i]) lzc24 = 5'(23 - i);
  endfunction

  wire sgn    = a_q[31] ^ b_q[31];
  wire a_zero = (a_q[30:0] == 31'd0);
  wire b_zero = (b_q[30:0] == 31'd0);
  wire a_inf  = (a_q[30:23] == 8'hFF) && (a_q[22:0] == 23'd0);
  wire b_inf  = (b_q[30:23] == 8'hFF) && (b_q[22:0] == 23'd0);
  wire a_nan  = (a_q[30:23] == 8'hFF) && (a_q[22:0] != 23'd0);
  wire b_nan  = (b_q[30:23] == 8'hFF) && (b_q[22:0] != 23'd0);

  logic [23:0]        sa, sb, na, nb;
  logic [4:0]         lza, lzb;
  logic signed [10:0] xa, xb, xe, ef;
  logic [47:0]        pp, pm, psh;
  logic [10:0]        shamt;
  logic [5:0]         sh;
  logic [63:0]        mask;
  logic               lost, g, st, inc;
  logic [24:0]        rnd;
  logic [22:0]        man;
  logic [31:0]        res;
  logic [2:0]         res_f;

  always_comb begin
    sa  = {|a_q[30:23], a_q[22:0]};
    sb  = {|b_q[30:23], b_q[22:0]};
    lza = lzc24(sa);
    lzb = lzc24(sb);
    na  = sa << lza;
    nb  = sb << lzb;
    xa  = ((a_q[30:23] == 8'd0) ? 11'sd1 : $signed({3'b0, a_q[30:23]})) - $signed({6'b0, lza});
    xb  = ((b_q[30:23] == 8'd0) ? 11'sd1 : $signed({3'b0, b_q[30:23]})) - $signed({6'b0, lzb});
    pp  = {24'd0, na} * {24'd0, nb};
    xe  = xa + xb - 11'sd127 + $signed({10'd0, pp[47]});
    pm  = pp[47] ? pp : (pp << 1);

    shamt = (xe < 11'sd1) ? 11'(11'sd1 - xe) : 11'd0;
    sh    = (shamt > 11'd63) ? 6'd63 : shamt[5:0];
    mask  = (64'd1 << sh) - 64'd1;
    lost  = |({16'd0, pm} & mask);
    psh   = pm >> sh;

    g   = psh[23];
    st  = (|psh[22:0]) | lost;
    inc = g & (st | psh[24]);
    rnd = {1'b0, psh[47:24]} + {24'd0, inc};

    ef = (xe < 11'sd1) ? 11'sd0 : xe;
    if (rnd[24]) begin
      ef  = ef + 11'sd1;
      man = 23'd0;
    end else begin
      man = rnd[22:0];
      if (ef == 11'sd0 && rnd[23]) ef = 11'sd1;
    end

    res_f = 3'b000;
    if (a_nan || b_nan || (a_inf && b_zero) || (a_zero && b_inf)) begin
      res   = {sgn, 9'h1FF, 22'd0};
      res_f = 3'b100;
    end else if (a_inf || b_inf || ef >= 11'sd255) begin
      res   = {sgn, 8'hFF, 23'd0};
      res_f = 3'b010;
    end else if (a_zero || b_zero) begin
      res = {sgn, 31'd0};
    end else begin
      res   = {sgn, ef[7:0], man};
      res_f = {2'b00, (ef == 11'sd0) && (man != 23'd0)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      prod  <= '0;
      flags <= '0;
    end else if (!busy) begin
      if (load) begin
        a_q  <= opa;
        b_q  <= opb;
        cnt  <= '0;
        busy <= 1'b1;
      end
    end else if (cnt == CW'(LAT - 1)) begin
      busy  <= 1'b0;
      prod  <= res;
      flags <= res_f;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fp32_seqmul_chk.sv
module fp32_seqmul_chk #(
  parameter int LAT = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        load,
  input logic        busy,
  input logic [31:0] prod,
  input logic [2:0]  flags
);
  localparam int CW = $clog2(LAT + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (load && !busy) |=> busy); // R2
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (run_len == CW'(LAT))); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$fell(busy) |-> ($stable(prod) && $stable(flags))); // R3
  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(flags)); // R5
  AST_NAN_CODE:    assert property (@(posedge clk) disable iff (!rst_n) flags[2] |-> (prod[30:0] == 31'h7FC00000)); // R6
  AST_INF_CODE:    assert property (@(posedge clk) disable iff (!rst_n) flags[1] |-> (prod[30:0] == 31'h7F800000)); // R7
  AST_SUBN_CODE:   assert property (@(posedge clk) disable iff (!rst_n) flags[0] |-> (prod[30:23] == 8'd0 && prod[22:0] != 23'd0)); // R8
endmodule

bind fp32_seqmul fp32_seqmul_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .busy(busy), .prod(prod), .flags(flags)
);

// File: tb/fp32_seqmul_tb.sv
`timescale 1ns/1ps
module fp32_seqmul_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] prod;
  logic [2:0]  flags;
  logic        busy;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp32_seqmul u_dut (.clk(clk), .rst_n(rst_n), .load(load), .opa(opa), .opb(opb),
                     .prod(prod), .flags(flags), .busy(busy));

  localparam int NV = 18;
  // {opa, opb, expected product, expected flags}
  localparam logic [98:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000},
    {32'h40000000, 32'h40400000, 32'h40C00000, 3'b000},
    {32'hBFC00000, 32'h40000000, 32'hC0400000, 3'b000},
    {32'h00000000, 32'h40A00000, 32'h00000000, 3'b000},
    {32'h80000000, 32'h40A00000, 32'h80000000, 3'b000},
    {32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b010},
    {32'h00000000, 32'h7F800000, 32'h7FC00000, 3'b100},
    {32'h7F800001, 32'hBF800000, 32'hFFC00000, 3'b100},
    {32'h7F000000, 32'h40000000, 32'h7F800000, 3'b010},
    {32'h00800000, 32'h3F000000, 32'h00400000, 3'b001},
    {32'h00000001, 32'h4B000000, 32'h00800000, 3'b000},
    {32'h00000001, 32'h3F000000, 32'h00000000, 3'b000},
    {32'h00000001, 32'h3F400000, 32'h00000001, 3'b001},
    {32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000},
    {32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000},
    {32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000},
    {32'h80000001, 32'h7F800000, 32'hFF800000, 3'b010},
    {32'h00000001, 32'h00000001, 32'h00000000, 3'b000}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 13, 14, 15: tag_of = "R4";
      2:                tag_of = "R1";
      3, 4:             tag_of = "R10";
      5, 8, 16:         tag_of = "R7";
      6, 7:             tag_of = "R6";
      9, 11, 12, 17:    tag_of = "R8";
      default:          tag_of = "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input string tg,
                     output logic [31:0] p, output logic [2:0] f);
    @(negedge clk); opa = a; opb = b; load = 1'b1;
    @(negedge clk); load = 1'b0;
    chk(busy == 1'b1, {tg, " R2 busy after capture"}, 32'(busy), 32'd1);
    repeat (9) @(negedge clk);
    chk(busy == 1'b1, {tg, " R3 busy in cycle 10"}, 32'(busy), 32'd1);
    @(negedge clk);
    chk(busy == 1'b0, {tg, " R3 busy low after 10 cycles"}, 32'(busy), 32'd0);
    p = prod; f = flags;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    logic [2:0]  f;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && prod == 32'd0 && flags == 3'd0, "R11 reset held", prod, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && prod == 32'd0 && flags == 3'd0, "R11 after release", {28'd0, busy, flags}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][98:67], VEC[i][66:35], tag_of(i), p, f);
      chk(p == VEC[i][34:3], $sformatf("%s product vec %0d", tag_of(i), i), p, VEC[i][34:3]);
      chk(f == VEC[i][2:0], $sformatf("%s flags vec %0d", tag_of(i), i), 32'(f), 32'(VEC[i][2:0]));
    end

    // R2: load during busy ignored
    @(negedge clk); opa = 32'h40400000; opb = 32'h40400000; load = 1'b1;
    @(negedge clk); opa = 32'h7F800000; opb = 32'h00000000;
    @(negedge clk); load = 1'b0;
    repeat (9) @(negedge clk);
    chk(busy == 1'b0, "R2 ignored load kept window", 32'(busy), 32'd0);
    chk(prod == 32'h41100000 && flags == 3'd0, "R2 ignored load kept operands", prod, 32'h41100000);

    // R3: result held while idle
    repeat (6) @(negedge clk);
    chk(prod == 32'h41100000 && busy == 1'b0, "R3 hold while idle", prod, 32'h41100000);

    // R3: reload in first idle cycle
    run(32'h40000000, 32'h40800000, "R3", p, f);
    opa = 32'hC0000000; opb = 32'h40000000; load = 1'b1;
    @(negedge clk); load = 1'b0;
    chk(busy == 1'b1, "R3 reload in first idle cycle", 32'(busy), 32'd1);
    chk(prod == 32'h41000000, "R3 old result during new run", prod, 32'h41000000);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && prod == 32'hC0800000, "R3 reload result", prod, 32'hC0800000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule